// File: doc/BRIEF.md
# JESD204 Transmit Transport Framer

This block sits between an application that produces converter samples and a JESD204B/C transmit link layer. On each accepted beat it takes one wide word that holds every channel's samples and rearranges the bits into octet streams, one stream per lane, in the frame order a transmit link expects. The frame size F (octets per lane per frame) follows from the lane, converter, sample and sample-width parameters. Only the values 1, 2 and 4 are accepted.

Both data sides use a valid/ready handshake. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the link side is taking its word in the same cycle, so a link that is always ready never stalls the application. While the output holds a word that the link does not take (`out_ready` low), the word and `out_valid` stay unchanged and `in_ready` is low. A separate plain vector of channel enables is passed on to the application side through a register. The data bus must still carry every channel, whether that channel is enabled or not.

Top module: `jtx_framer`

## Requirements
- R1: F = M*S*NP/(8*L) must be 1, 2 or 4, and any other parameter set stops elaboration. Configurations with F of 1, 2 and 4 each frame correctly.
- R2: Input layout. Sample i (0 = earliest) of converter c occupies bits [(c*SPC+i)*NP +: NP] of `in_data`, where SPC = S*(OPB/F) is the number of samples per converter per beat.
- R3: Octet order. Frame j of a beat concatenates its samples MSB first: converter 0 samples j*S..j*S+S-1, then converter 1, and so on. Octet k of that frame (k=0 is the most significant) goes to lane k/F at time slot j*F + k%F. Lane l occupies `out_data[l*OPB*8 +: OPB*8]`, and time slot t is byte t of that lane (slot 0 in the lowest byte).
- R4: When NP > N, the low NP-N bits of every sample are sent as zero, whatever the input carries there.
- R5: A word accepted on edge t appears on `out_data` with `out_valid` high after edge t, which is one cycle of latency.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged and `in_ready` is low.
- R7: `in_ready` is high in every cycle where `out_ready` is high.
- R8: `chan_en_o` equals the `chan_en_i` value from the previous clock edge, and it does not depend on data traffic.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `chan_en_o` are cleared.
- R10: If the link takes the output word and no new word is accepted, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Application word present |
| in_ready | output | 1 | Framer can take a word |
| in_data | input | M*S*(OPB/F)*NP | All channels' samples, converter-major |
| out_valid | output | 1 | Framed word present |
| out_ready | input | 1 | Link layer takes the word |
| out_data | output | L*OPB*8 | Lane-concatenated octet streams |
| chan_en_i | input | M | Channel enables from configuration |
| chan_en_o | output | M | Registered per-channel enable toward application |

## Verification
The assertions check the handshake on every cycle: load into the output register, holding under back-pressure, the link between `out_ready` and `in_ready`, draining, and the one-cycle follow of the channel enables. Only the bench scenarios can show the content of the bit rearrangement and the zero padding. To do this, the bench walks a single set bit across every input position for three configurations, one each with F of 1, 2 and 4. It compares each result against a frame built arithmetically from the requirements, and it adds fixed patterns with hand-computed results.

// File: rtl/jtx_pkg.sv
package jtx_pkg;

  // Octets per lane per frame.
  function automatic int calc_f(int l, int m, int s, int np);
    return (m * s * np) / (8 * l);
  endfunction

  // Input bit feeding output bit b of time slot p on lane l.
  function automatic int src_bit(int l, int p, int b, int f, int s, int np, int spc);
    int fr, k, t, sidx, c, si, sb;
    fr   = p / f;
    k    = l * f + (p % f);
    t    = k * 8 + (7 - b);
    sidx = t / np;
    c    = sidx / s;
    si   = sidx % s;
    sb   = np - 1 - (t % np);
    return (c * spc + fr * s + si) * np + sb;
  endfunction

  // True when that output bit falls in the padding below an N-bit sample.
  function automatic bit is_pad(int l, int p, int b, int f, int n, int np);
    int k, t;
    k = l * f + (p % f);
    t = k * 8 + (7 - b);
    return (np - 1 - (t % np)) < (np - n);
  endfunction

endpackage

// File: rtl/jtx_octet_map.sv
module jtx_octet_map #(
  parameter int L   = 4,
  parameter int OPB = 4,
  parameter int F   = 1,
  parameter int S   = 1,
  parameter int N   = 16,
  parameter int NP  = 16,
  parameter int SPC = 4,
  parameter int W   = 128
) (
  input  logic [W-1:0] samples,
  output logic [W-1:0] octets
);

  for (genvar gl = 0; gl < L; gl++) begin : g_lane
    for (genvar gp = 0; gp < OPB; gp++) begin : g_slot
      for (genvar gb = 0; gb < 8; gb++) begin : g_bit
        localparam int SRC = jtx_pkg::src_bit(gl, gp, gb, F, S, NP, SPC);
        localparam bit PAD = jtx_pkg::is_pad(gl, gp, gb, F, N, NP);
        localparam int DST = gl * OPB * 8 + gp * 8 + gb;
        if (PAD) begin : g_pad
          assign octets[DST] = 1'b0 & samples[SRC];
        end else begin : g_route
          assign octets[DST] = samples[SRC];
        end
      end
    end
  end

endmodule

// File: rtl/jtx_stage.sv
module jtx_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/jtx_framer.sv
module jtx_framer #(
  parameter int L   = 4,
  parameter int M   = 2,
  parameter int S   = 1,
  parameter int N   = 16,
  parameter int NP  = 16,
  parameter int OPB = 4,
  localparam int F     = jtx_pkg::calc_f(L, M, S, NP),
  localparam int FPB   = OPB / F,
  localparam int SPC   = S * FPB,
  localparam int IN_W  = M * SPC * NP,
  localparam int OUT_W = L * OPB * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  input  logic [M-1:0]     chan_en_i,
  output logic [M-1:0]     chan_en_o
);

  if (!(F == 1 || F == 2 || F == 4) || (M * S * NP) != (8 * L * F)
      || (OPB % F) != 0 || IN_W != OUT_W || N > NP) begin : g_bad_cfg
    $error("jtx_framer: unsupported frame configuration");
  end

  logic [OUT_W-1:0] mapped;

  jtx_octet_map #(
    .L(L), .OPB(OPB), .F(F), .S(S), .N(N), .NP(NP), .SPC(SPC), .W(OUT_W)
  ) u_map (
    .samples (in_data),
    .octets  (mapped)
  );

  jtx_stage #(.W(OUT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (mapped),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) chan_en_o <= '0;
    else        chan_en_o <= chan_en_i;
  end

endmodule

// File: rtl/jtx_framer_chk.sv
module jtx_framer_chk #(
  parameter int OUT_W = 128,
  parameter int M     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [M-1:0]     chan_en_i,
  input logic [M-1:0]     chan_en_o
);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chan_en_o == $past(chan_en_i));

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !in_valid |=> !out_valid);

endmodule

bind jtx_framer jtx_framer_chk #(.OUT_W(OUT_W), .M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .chan_en_i (chan_en_i),
  .chan_en_o (chan_en_o)
);

// File: tb/jtx_framer_tb.sv
module jtx_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [127:0] din = '0;
  logic [1:0] en_in = '0;

  logic in_ready_a, in_ready_b, in_ready_c;
  logic ov_a, ov_b, ov_c;
  logic [127:0] od_a;
  logic [31:0] od_b, od_c;
  logic [1:0] en_a, en_b, en_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // F = 1 (default configuration)
  jtx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
    .in_data(din), .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a),
    .chan_en_i(en_in), .chan_en_o(en_a));

  // F = 2 with 12-bit samples in 16-bit slots
  jtx_framer #(.L(2), .M(2), .S(1), .N(12), .NP(16), .OPB(2)) u_dut_f2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_data(din[31:0]), .out_valid(ov_b), .out_ready(out_ready), .out_data(od_b),
    .chan_en_i(en_in), .chan_en_o(en_b));

  // F = 4 on a single lane
  jtx_framer #(.L(1), .M(2), .S(1), .N(16), .NP(16), .OPB(4)) u_dut_f4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_data(din[31:0]), .out_valid(ov_c), .out_ready(out_ready), .out_data(od_c),
    .chan_en_i(en_in), .chan_en_o(en_c));

  // Builds each frame as a bit string from the requirements, then deals its octets to lanes.
  function automatic logic [127:0] expect_map(int l, int m, int s, int n, int np, int opb,
                                              logic [127:0] x);
    int f, fpb, spc, fb;
    logic [127:0] res, acc, smp, msk;
    f = (m * s * np) / (8 * l);
    fpb = opb / f;
    spc = s * fpb;
    fb = m * s * np;
    res = '0;
    msk = (128'(1) << np) - 1;
    for (int fr = 0; fr < fpb; fr++) begin
      acc = '0;
      for (int c = 0; c < m; c++) begin
        for (int si = 0; si < s; si++) begin
          smp = (x >> ((c * spc + fr * s + si) * np)) & msk;
          smp = (smp >> (np - n)) << (np - n);
          acc = (acc << np) | smp;
        end
      end
      for (int k = 0; k < l * f; k++) begin
        res[(k / f) * opb * 8 + (fr * f + k % f) * 8 +: 8] = 8'((acc >> (fb - 8 * (k + 1))) & 128'hFF);
      end
    end
    return res;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({"R1 R2 R3 F=1 ", tag}, od_a, expect_map(4, 2, 1, 16, 16, 4, din));
    check({"R1 R3 R4 F=2 ", tag}, {96'd0, od_b}, expect_map(2, 2, 1, 12, 16, 2, {96'd0, din[31:0]}));
    check({"R1 R3 F=4 ", tag}, {96'd0, od_c}, expect_map(1, 2, 1, 16, 16, 4, {96'd0, din[31:0]}));
    check({"R5 valid ", tag}, {125'd0, ov_a, ov_b, ov_c}, 128'd7);
  endtask

  task automatic send(logic [127:0] v, string tag);
    @(negedge clk);
    din = v;
    in_valid = 1'b1;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    logic [127:0] held;
    en_in = 2'b11;
    repeat (3) @(negedge clk);
    // R9: reset clears valid and enables even with enables requested
    check("R9 out_valid", {125'd0, ov_a, ov_b, ov_c}, 128'd0);
    check("R9 chan_en_o", {122'd0, en_a, en_b, en_c}, 128'd0);
    rst_n = 1'b1;
    en_in = 2'b00;
    @(negedge clk);

    // R4 hand case: samples 0x1234 / 0xABCD, 12-bit, F=2 -> lanes C0AB, 3012
    send(128'hABCD_1234, "hand");
    check("R4 hand F=2", {96'd0, od_b}, 128'hC0AB_3012);
    // R3 hand case for F=4: conv0 octets then conv1 octets in time order
    check("R3 hand F=4", {96'd0, od_c}, 128'hCDAB_3412);

    // R2 R3: walk a single set bit across every input position
    for (int i = 0; i < 128; i++) send(128'd1 << i, "walk");
    send({128{1'b1}}, "ones");
    send({32{4'hA}}, "alt");
    send(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, "mix");

    // R6: back-pressure holds the word and blocks input
    held = od_a;
    @(negedge clk);
    out_ready = 1'b0;
    din = 128'h5555_6666_7777_8888_9999_aaaa_bbbb_cccc;
    #1;
    check("R6 in_ready low", {127'd0, in_ready_a}, 128'd0);
    @(negedge clk);
    check("R6 data held", od_a, held);
    check("R6 valid held", {127'd0, ov_a}, 128'd1);
    @(negedge clk);
    check("R6 data held 2", od_a, held);
    out_ready = 1'b1;
    #1;
    check("R7 in_ready", {125'd0, in_ready_a, in_ready_b, in_ready_c}, 128'd7);
    @(negedge clk);
    check_all("after stall");

    // R10: drain with no new input
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 drained", {125'd0, ov_a, ov_b, ov_c}, 128'd0);
    check("R7 idle ready", {125'd0, in_ready_a, in_ready_b, in_ready_c}, 128'd7);

    // R8: enables follow one edge later, independent of data
    for (int e = 0; e < 4; e++) begin
      en_in = 2'(e);
      #1;
      check("R8 before edge", {126'd0, en_a}, 128'(e == 0 ? 0 : e - 1));
      @(negedge clk);
      check("R8 after edge", {122'd0, en_a, en_b, en_c}, {122'd0, 2'(e), 2'(e), 2'(e)});
    end
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule